// File: doc/BRIEF.md
# Synchronous Byte-Lane SRAM with Selectable Read Pipeline

This block is a small synchronous static memory whose address, write data and command inputs are all sampled on the rising clock edge. Storage is organised as four byte lanes of nine bits each, giving a 36-bit word, and the depth is set by an address-width parameter. The shared data bus of a real part is split into a data input port, a data output port and a drive-enable output, which the surrounding logic uses to control a bidirectional pad or bus mux.

Every selected clock edge carries exactly one command, either a read or a write. A write is requested by the all-lanes write strobe or by the byte write strobe together with per-lane selects. The all-lanes strobe wins over the per-lane controls. Any other selected edge is a read. A mode input picks between flow-through reads and pipelined reads. Flow-through reads present data in the cycle after the address edge. Pipelined reads pass the data through an output register and add one cycle. The output drive is switched off one stage ahead of the data path after a deselect or a write.

The output enable and the sleep request act on the drive enable without waiting for a clock edge. While sleep is requested, commands are ignored and the stored contents are kept. The burst address sequencing of a full device belongs to a separate counter block and is not part of this one. Every access supplies its own address.

Top module: `sram_sync_top`

## Requirements
- R1: With `pipe_sel` = 0 (flow-through), a read registered at edge k sets `dq_oe` high and puts the stored word on `dout` after edge k and before edge k+1.
- R2: With `pipe_sel` = 1 (pipelined), a read registered at edge k produces no new drive after edge k. Its word appears on `dout` with `dq_oe` high after edge k+1.
- R3: A deselect or write registered at edge k turns the drive off one stage early. In pipelined mode the word of a read registered at edge k-1 is still driven between edges k and k+1, and `dq_oe` is low after edge k+1. In flow-through mode `dq_oe` is low right after edge k.
- R4: With `wr_all_n` = 0 on a selected edge, all four lanes are written, whatever `wr_byte_n` and `lane_sel_n` hold.
- R5: With `wr_all_n` = 1 and `wr_byte_n` = 0, only lanes i with `lane_sel_n[i]` = 0 are written. Lane i occupies bits [9i+8:9i] of `din` and `dout`. With no lane selected, the edge writes nothing and is still not a read.
- R6: The device is selected only when `sel_a_n` = 0, `sel_b` = 1 and `sel_c_n` = 0. An edge with any of the three deasserted neither writes nor reads.
- R7: While `sleep_req` is high, `dq_oe` is low at once and commands at edges are ignored. Stored contents are kept and can be read back after sleep ends.
- R8: `out_en_n` = 1 forces `dq_oe` low at once, without a clock edge. The pending read data is still driven when `out_en_n` returns to 0 within the same cycle.
- R9: A write registered at edge k is committed at that edge. A read of the same address registered at edge k+1 returns the new word.
- R10: After reset, and until the first read, `dq_oe` is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock for all synchronous inputs |
| rst_n | input | 1 | Active-low reset of the control pipeline (not of storage) |
| addr | input | ADDR_W | Word address, sampled at each edge |
| din | input | 36 | Write data, four 9-bit lanes |
| dout | output | 36 | Read data, valid while `dq_oe` is high |
| dq_oe | output | 1 | Data bus drive enable |
| sel_a_n | input | 1 | Chip select, active low |
| sel_b | input | 1 | Chip select, active high |
| sel_c_n | input | 1 | Chip select, active low |
| wr_all_n | input | 1 | Write all lanes, active low |
| wr_byte_n | input | 1 | Byte write strobe, active low |
| lane_sel_n | input | 4 | Per-lane write selects, active low |
| out_en_n | input | 1 | Asynchronous output enable, active low |
| sleep_req | input | 1 | Asynchronous sleep request, active high |
| pipe_sel | input | 1 | Read mode: 0 flow-through, 1 pipelined |

## Verification
Every cycle, assertions check four things: each lane write enable leaves the addressed lane holding the sampled data one edge later, a sleeping edge leaves the registered command idle, the pipelined drive enable never rises without a read registered one stage back, and a flow-through write or a sleep request keeps the bus undriven. Other behaviour depends on specific input sequences, so only the bench scenarios show it. These include the exact cycle at which each mode first presents data, the extra cycle that pipelined data survives a following deselect, the lane patterns that byte writes leave behind, the effect of each individual chip select, and the return of the pending word when the output enable is released within a cycle.

// File: rtl/sram_pkg.sv
`timescale 1ns/1ps
package sram_pkg;

   typedef enum logic [1:0] {
      CMD_IDLE  = 2'd0,
      CMD_READ  = 2'd1,
      CMD_WRITE = 2'd2
   } sram_cmd_e;

   // Lane write mask: all-lanes strobe beats the per-lane controls.
   function automatic logic [3:0] lane_mask4(input logic all_n,
                                             input logic byte_n,
                                             input logic [3:0] sel_n);
      if (!all_n)       return 4'hF;
      else if (!byte_n) return ~sel_n;
      else              return 4'h0;
   endfunction

endpackage

// File: rtl/sram_cmd_decode.sv
`timescale 1ns/1ps
module sram_cmd_decode
   import sram_pkg::*;
#(
   parameter int ADDR_W = 6,
   parameter int LANES  = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] addr,
   input  logic              sel_a_n,
   input  logic              sel_b,
   input  logic              sel_c_n,
   input  logic              wr_all_n,
   input  logic              wr_byte_n,
   input  logic [LANES-1:0]  lane_sel_n,
   input  logic              sleep_req,
   output logic [LANES-1:0]  lane_we,
   output sram_cmd_e         cmd_q,
   output logic [ADDR_W-1:0] raddr_q
);

   generate
      if (LANES != 4) begin : g_bad_lanes
         $error("sram_cmd_decode: LANES must be 4");
      end
      if (ADDR_W < 1 || ADDR_W > 12) begin : g_bad_addr
         $error("sram_cmd_decode: ADDR_W out of range");
      end
   endgenerate

   logic chip_on;
   logic wr_req;

   always_comb begin
      chip_on = !sel_a_n && sel_b && !sel_c_n && !sleep_req && rst_n;
      wr_req  = !wr_all_n || !wr_byte_n;
      lane_we = chip_on ? lane_mask4(wr_all_n, wr_byte_n, lane_sel_n) : '0;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cmd_q   <= CMD_IDLE;
         raddr_q <= '0;
      end else begin
         if (!chip_on)    cmd_q <= CMD_IDLE;
         else if (wr_req) cmd_q <= CMD_WRITE;
         else             cmd_q <= CMD_READ;
         if (chip_on && !wr_req) raddr_q <= addr;
      end
   end

   // R7: an edge seen while sleeping registers no command
   p_sleep_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
      sleep_req |=> (cmd_q == CMD_IDLE));

endmodule

// File: rtl/sram_lane_array.sv
`timescale 1ns/1ps
module sram_lane_array #(
   parameter int ADDR_W = 6,
   parameter int LANES  = 4,
   parameter int LANE_W = 9,
   localparam int DEPTH  = 1 << ADDR_W,
   localparam int DATA_W = LANES * LANE_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [LANES-1:0]  lane_we,
   input  logic [ADDR_W-1:0] waddr,
   input  logic [DATA_W-1:0] wdata,
   input  logic [ADDR_W-1:0] raddr,
   output logic [DATA_W-1:0] rdata
);

   generate
      if (LANE_W < 1 || DEPTH * DATA_W > 65536) begin : g_bad_size
         $error("sram_lane_array: storage size out of range");
      end
   endgenerate

   for (genvar l = 0; l < LANES; l++) begin : g_lane
      logic [LANE_W-1:0] store [DEPTH];

      always_ff @(posedge clk) begin
         if (lane_we[l]) store[waddr] <= wdata[l*LANE_W +: LANE_W];
      end

      assign rdata[l*LANE_W +: LANE_W] = store[raddr];

      // R5 / R4: an enabled lane holds the sampled data after the edge
      p_lane_commit_r5: assert property (@(posedge clk) disable iff (!rst_n)
         lane_we[l] |=> (store[$past(waddr)] == $past(wdata[l*LANE_W +: LANE_W])));
   end

endmodule

// File: rtl/sram_read_path.sv
`timescale 1ns/1ps
module sram_read_path #(
   parameter int DATA_W = 36
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              pipe_sel,
   input  logic              rd_q,
   input  logic [DATA_W-1:0] rdata,
   input  logic              out_en_n,
   input  logic              sleep_req,
   output logic [DATA_W-1:0] dout,
   output logic              dq_oe
);

   logic              pipe_vld;
   logic [DATA_W-1:0] pipe_data;
   logic              drive_raw;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) pipe_vld <= 1'b0;
      else        pipe_vld <= rd_q;
   end

   always_ff @(posedge clk) begin
      pipe_data <= rdata;
   end

   always_comb begin
      drive_raw = pipe_sel ? pipe_vld  : rd_q;
      dout      = pipe_sel ? pipe_data : rdata;
      dq_oe     = drive_raw && !out_en_n && !sleep_req;
   end

endmodule

// File: rtl/sram_sync_top.sv
`timescale 1ns/1ps
module sram_sync_top
   import sram_pkg::*;
#(
   parameter int ADDR_W = 6,
   parameter int LANES  = 4,
   parameter int LANE_W = 9,
   localparam int DATA_W = LANES * LANE_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] addr,
   input  logic [DATA_W-1:0] din,
   output logic [DATA_W-1:0] dout,
   output logic              dq_oe,
   input  logic              sel_a_n,
   input  logic              sel_b,
   input  logic              sel_c_n,
   input  logic              wr_all_n,
   input  logic              wr_byte_n,
   input  logic [LANES-1:0]  lane_sel_n,
   input  logic              out_en_n,
   input  logic              sleep_req,
   input  logic              pipe_sel
);

   logic [LANES-1:0]  lane_we;
   sram_cmd_e         cmd_q;
   logic [ADDR_W-1:0] raddr_q;
   logic [DATA_W-1:0] rdata;
   logic              rd_q;

   assign rd_q = (cmd_q == CMD_READ);

   sram_cmd_decode #(.ADDR_W(ADDR_W), .LANES(LANES)) i_decode (
      .clk(clk), .rst_n(rst_n), .addr(addr),
      .sel_a_n(sel_a_n), .sel_b(sel_b), .sel_c_n(sel_c_n),
      .wr_all_n(wr_all_n), .wr_byte_n(wr_byte_n), .lane_sel_n(lane_sel_n),
      .sleep_req(sleep_req), .lane_we(lane_we), .cmd_q(cmd_q), .raddr_q(raddr_q)
   );

   sram_lane_array #(.ADDR_W(ADDR_W), .LANES(LANES), .LANE_W(LANE_W)) i_array (
      .clk(clk), .rst_n(rst_n), .lane_we(lane_we), .waddr(addr),
      .wdata(din), .raddr(raddr_q), .rdata(rdata)
   );

   sram_read_path #(.DATA_W(DATA_W)) i_rdpath (
      .clk(clk), .rst_n(rst_n), .pipe_sel(pipe_sel), .rd_q(rd_q),
      .rdata(rdata), .out_en_n(out_en_n), .sleep_req(sleep_req),
      .dout(dout), .dq_oe(dq_oe)
   );

   // R3 / R2: pipelined drive needs a read registered one stage back
   p_pipe_turnoff_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (pipe_sel && $past(pipe_sel) && !$past(rd_q)) |-> !dq_oe);

   // R3: flow-through bus is released by a registered write
   p_flow_write_off_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (!pipe_sel && cmd_q == CMD_WRITE) |-> !dq_oe);

   // R7: sleeping device never drives
   p_sleep_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
      sleep_req |-> !dq_oe);

endmodule

// File: tb/test_sram_sync_top.sv
`timescale 1ns/1ps
module test_sram_sync_top;

   localparam int AW = 6;
   localparam int DW = 36;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [AW-1:0] addr = '0;
   logic [DW-1:0] din = '0;
   logic [DW-1:0] dout;
   logic          dq_oe;
   logic          sel_a_n = 1'b1, sel_b = 1'b0, sel_c_n = 1'b1;
   logic          wr_all_n = 1'b1, wr_byte_n = 1'b1;
   logic [3:0]    lane_sel_n = 4'hF;
   logic          out_en_n = 1'b0, sleep_req = 1'b0, pipe_sel = 1'b0;

   int checks = 0;
   int errors = 0;
   logic [DW-1:0] model [1 << AW];

   always #10 clk = ~clk;   // 50 MHz

   sram_sync_top #(.ADDR_W(AW)) i_sram_sync_top (
      .clk(clk), .rst_n(rst_n), .addr(addr), .din(din), .dout(dout), .dq_oe(dq_oe),
      .sel_a_n(sel_a_n), .sel_b(sel_b), .sel_c_n(sel_c_n),
      .wr_all_n(wr_all_n), .wr_byte_n(wr_byte_n), .lane_sel_n(lane_sel_n),
      .out_en_n(out_en_n), .sleep_req(sleep_req), .pipe_sel(pipe_sel)
   );

   task automatic chk(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic step();
      @(posedge clk);
      @(negedge clk);
   endtask

   task automatic go_idle();
      sel_a_n = 1'b1; sel_b = 1'b0; sel_c_n = 1'b1;
      wr_all_n = 1'b1; wr_byte_n = 1'b1; lane_sel_n = 4'hF;
   endtask

   task automatic go_sel();
      sel_a_n = 1'b0; sel_b = 1'b1; sel_c_n = 1'b0;
   endtask

   task automatic put_read(input logic [AW-1:0] a);
      go_sel(); wr_all_n = 1'b1; wr_byte_n = 1'b1; lane_sel_n = 4'hF; addr = a;
   endtask

   task automatic put_gw(input logic [AW-1:0] a, input logic [DW-1:0] d);
      go_sel(); wr_all_n = 1'b0; wr_byte_n = 1'b1; lane_sel_n = 4'hF; addr = a; din = d;
      model[a] = d;
   endtask

   task automatic put_bw(input logic [AW-1:0] a, input logic [DW-1:0] d, input logic [3:0] sn);
      go_sel(); wr_all_n = 1'b1; wr_byte_n = 1'b0; lane_sel_n = sn; addr = a; din = d;
      for (int i = 0; i < 4; i++)
         if (!sn[i]) model[a][9*i +: 9] = d[9*i +: 9];
   endtask

   // flow-through read with check of drive and data
   task automatic flow_read(input logic [AW-1:0] a, input string req);
      put_read(a); step();
      chk(req, {35'd0, dq_oe}, 36'd1);
      chk(req, dout, model[a]);
      go_idle();
   endtask

   task automatic t_reset();
      chk("R10", {35'd0, dq_oe}, 36'd0);
      rst_n = 1'b1;
      step(); step();
      chk("R10", {35'd0, dq_oe}, 36'd0);
   endtask

   task automatic t_global_write();
      // R4: all-lanes strobe overrides byte controls
      put_gw(6'd5, 36'h9_1234_5678);
      wr_byte_n = 1'b0; lane_sel_n = 4'b1010;
      step();
      flow_read(6'd5, "R9");      // read on the edge right after the write
      put_gw(6'd6, 36'hA_AAAA_5555); step();
      put_gw(6'd7, 36'h5_0F0F_F0F0); step();
      go_idle(); step();
      flow_read(6'd6, "R1");
      flow_read(6'd7, "R4");
      step();
   endtask

   task automatic t_byte_write();
      put_gw(6'd10, 36'h0_0000_0000); step();
      put_bw(6'd10, 36'hF_FFFF_FFFF, 4'b0101); step();   // lanes 1 and 3
      go_idle(); step();
      flow_read(6'd10, "R5");
      chk("R5", model[10], 36'hF_F803_FE00);
      // byte strobe with no lane: no write, not a read
      put_bw(6'd10, 36'h1_2345_6789, 4'hF); step();
      chk("R5", {35'd0, dq_oe}, 36'd0);
      go_idle(); step();
      flow_read(6'd10, "R5");
      step();
   endtask

   task automatic t_chip_enable();
      put_gw(6'd20, 36'h3_3333_3333); step();
      for (int v = 0; v < 3; v++) begin
         go_idle(); step();
         put_gw(6'd20, 36'hC_CCCC_CCCC);
         model[20] = 36'h3_3333_3333;   // write must not land
         if (v == 0) sel_a_n = 1'b1;
         if (v == 1) sel_b = 1'b0;
         if (v == 2) sel_c_n = 1'b1;
         step();
         put_read(6'd20);
         if (v == 0) sel_a_n = 1'b1;
         if (v == 1) sel_b = 1'b0;
         if (v == 2) sel_c_n = 1'b1;
         step();
         chk("R6", {35'd0, dq_oe}, 36'd0);
      end
      go_idle(); step();
      flow_read(6'd20, "R6");
      step();
   endtask

   task automatic t_pipeline();
      go_idle(); pipe_sel = 1'b1; step(); step();
      put_gw(6'd30, 36'h1_1111_0000); step();
      put_gw(6'd31, 36'h2_2222_0001); step();
      go_idle(); step();
      put_read(6'd30); step();
      chk("R2", {35'd0, dq_oe}, 36'd0);
      put_read(6'd31); step();
      chk("R2", {35'd0, dq_oe}, 36'd1);
      chk("R2", dout, model[30]);
      go_idle(); step();                     // deselect registered
      chk("R3", {35'd0, dq_oe}, 36'd1);
      chk("R3", dout, model[31]);
      step();
      chk("R3", {35'd0, dq_oe}, 36'd0);
      // write following a read
      put_read(6'd30); step();
      put_gw(6'd32, 36'h7_7777_7777); step();
      chk("R3", dout, model[30]);
      go_idle(); step();
      chk("R3", {35'd0, dq_oe}, 36'd0);
      pipe_sel = 1'b0; step(); step();
   endtask

   task automatic t_flow_deselect();
      put_read(6'd31); step();
      chk("R1", dout, model[31]);
      go_idle(); step();
      chk("R3", {35'd0, dq_oe}, 36'd0);
   endtask

   task automatic t_sleep();
      put_gw(6'd40, 36'h4_0404_0404); step();
      put_read(6'd40); step();
      chk("R7", {35'd0, dq_oe}, 36'd1);
      sleep_req = 1'b1; #2;
      chk("R7", {35'd0, dq_oe}, 36'd0);
      put_gw(6'd40, 36'hB_BBBB_BBBB);
      model[40] = 36'h4_0404_0404;           // ignored while asleep
      step();
      chk("R7", {35'd0, dq_oe}, 36'd0);
      go_idle(); step();
      sleep_req = 1'b0; step();
      flow_read(6'd40, "R7");
      step();
   endtask

   task automatic t_out_enable();
      put_read(6'd40); step();
      go_idle();
      out_en_n = 1'b1; #2;
      chk("R8", {35'd0, dq_oe}, 36'd0);
      out_en_n = 1'b0; #2;
      chk("R8", {35'd0, dq_oe}, 36'd1);
      chk("R8", dout, model[40]);
      step();
   endtask

   initial begin
      #(20 * 20000);
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      @(negedge clk); @(negedge clk);
      t_reset();
      t_global_write();
      t_byte_write();
      t_chip_enable();
      t_pipeline();
      t_flow_deselect();
      t_sleep();
      t_out_enable();
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule